// File: doc/BRIEF.md
# GPIO Interrupt Cause Collector

This block gathers events from 32 general-purpose input pins into a cause register. Each pin passes through a two-flop synchronizer. A rising edge on a pin sets its cause bit, and the bit stays set until software clears it. A mask register decides which pending bits count as live interrupts. The live bits are ORed in groups of eight onto a four-wire cascade bus, which feeds the upper word of a main interrupt controller.

Software reaches the block through a simple word-wide register port. Writes take effect on the clock edge and reads are combinational. Clearing works by writing zeros: a bit written as 0 clears, and a bit written as 1 leaves the cause bit as it is. Writing the inverted one-hot pattern of a pin therefore acknowledges that pin alone. A read-only vector register names the highest-numbered live pin, so the handler can dispatch without scanning the register.

The block has no state machine. It is three pieces of registered or combinational logic: the edge capture, the cause and mask store, and the priority pick. The address decode in the top joins them.

Top module: `gpio_irq_collector`

## Requirements
- R1: After reset, the cause register and the mask register both read 0, every cascade output is low, and the vector register reads 0x40.
- R2: A rising edge on a pin sets the matching cause bit three clock edges after the pin first reads high at a clock edge. A pin held high after its bit has been cleared does not set the bit again.
- R3: A write to the cause register (byte offset 0x08) clears each cause bit written as 0 and leaves unchanged each bit written as 1. Cause bits never clear by any other means.
- R4: If a pin edge sets a cause bit in the same cycle that a cause write clears it, the bit ends up set.
- R5: The mask register (byte offset 0x0C) reads back the last value written to it. A mask bit of 1 enables the matching pin.
- R6: Cascade output k (k = 0..3) is high exactly when some pin from 8k to 8k+7 is both pending in cause and enabled in mask.
- R7: The vector register (byte offset 0x10) reads {24'b0, valid, 2'b10, index[4:0]}. Here index is the highest-numbered pin that is pending and enabled. When no pin is live, valid is 0 and index is 0.
- R8: A pending pin whose mask bit is 0 stays set in the cause register but affects neither the cascade outputs nor the vector register.
- R9: Writes to the vector offset or to any unmapped offset change no register. Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Asynchronous active-high pin inputs |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| grp_irq | output | 4 | Cascade summary, one bit per group of eight pins |

## Verification
The assertions assume that each pin stays at a level for at least two clock cycles, so that the synchronizer sees every edge. They also assume that the write strobe is a clean one-cycle pulse with a stable word-aligned offset. The stimulus meets these assumptions. It changes pins and bus signals only on falling clock edges and holds each pin level for four or more cycles. It returns all pins low before each new pattern, so that every row starts from a known edge state. The same-cycle set-and-clear case is produced by counting edges, so that the write strobe lands exactly on the cycle in which the edge pulse is active.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int PIN_COUNT   = 32;
    localparam int GROUP_SIZE  = 8;
    localparam int OFFSET_W    = 5;

    localparam logic [OFFSET_W-1:0] OFS_CAUSE  = 5'h08;
    localparam logic [OFFSET_W-1:0] OFS_MASK   = 5'h0C;
    localparam logic [OFFSET_W-1:0] OFS_VECTOR = 5'h10;

    // group code placed above the pin index in the vector word
    localparam logic [1:0] PIN_GROUP_CODE = 2'b10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_MASK,
        SEL_VECTOR
    } reg_sel_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    for (genvar p = 0; p < WIDTH; p++) begin : g_edge
        assign rise_o[p] = sync_q[p] & ~last_q[p];
    end

    // an edge pulse never lasts two cycles in a row
    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o & $past(rise_o)) == '0); // R2
endmodule

// File: rtl/gpio_cause_mask.sv
module gpio_cause_mask #(
    parameter int WIDTH      = 32,
    parameter int GROUP_SIZE = 8,
    localparam int GROUPS    = WIDTH / GROUP_SIZE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  set_ev_i,
    input  logic              cause_we_i,
    input  logic              mask_we_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  cause_o,
    output logic [WIDTH-1:0]  mask_o,
    output logic [WIDTH-1:0]  live_o,
    output logic [GROUPS-1:0] grp_o
);
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] keep_bits;

    always_comb begin
        keep_bits = cause_we_i ? wdata_i : '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            // edge sets take priority over a zero write
            cause_q <= (cause_q & keep_bits) | set_ev_i;
            if (mask_we_i) begin
                mask_q <= wdata_i;
            end
        end
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign live_o  = cause_q & mask_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        assign grp_o[g] = |live_o[g*GROUP_SIZE +: GROUP_SIZE];
    end

    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~$past(cause_q) & ~$past(set_ev_i)) == '0); // R2
    AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cause_we_i) |-> (($past(cause_q) & ~cause_q) == '0)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_ev_i) & ~cause_q) == '0); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mask_we_i) |-> $stable(mask_q)); // R5
endmodule

// File: rtl/gpio_prio_pick.sv
module gpio_prio_pick #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] live_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] index_o
);
    always_comb begin
        index_o = '0;
        for (int b = 0; b < WIDTH; b++) begin
            if (live_i[b]) begin
                index_o = IDX_W'(b);
            end
        end
    end

    assign valid_o = |live_i;

    // chosen pin is live and nothing above it is live
    AST_PICK_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((live_i >> index_o) == WIDTH'(1))); // R7
    AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (index_o == '0)); // R7
endmodule

// File: rtl/gpio_irq_collector.sv
module gpio_irq_collector
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = PIN_COUNT,
    parameter int GRP_PINS   = GROUP_SIZE,
    parameter int ADDR_W     = OFFSET_W,
    localparam int NUM_GRPS  = NUM_PINS / GRP_PINS,
    localparam int IDX_W     = $clog2(NUM_PINS),
    localparam int VEC_W     = IDX_W + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic [NUM_GRPS-1:0] grp_irq
);
    reg_sel_e            sel;
    logic [NUM_PINS-1:0] rise_ev;
    logic [NUM_PINS-1:0] cause_val;
    logic [NUM_PINS-1:0] mask_val;
    logic [NUM_PINS-1:0] live_val;
    logic                pick_valid;
    logic [IDX_W-1:0]    pick_index;
    logic [VEC_W-1:0]    vec_word;

    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_CAUSE):  sel = SEL_CAUSE;
            ADDR_W'(OFS_MASK):   sel = SEL_MASK;
            ADDR_W'(OFS_VECTOR): sel = SEL_VECTOR;
            default:             sel = SEL_NONE;
        endcase
    end

    gpio_edge_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_i),
        .rise_o (rise_ev)
    );

    gpio_cause_mask #(.WIDTH(NUM_PINS), .GROUP_SIZE(GRP_PINS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ev_i   (rise_ev),
        .cause_we_i (bus_we && sel == SEL_CAUSE),
        .mask_we_i  (bus_we && sel == SEL_MASK),
        .wdata_i    (bus_wdata),
        .cause_o    (cause_val),
        .mask_o     (mask_val),
        .live_o     (live_val),
        .grp_o      (grp_irq)
    );

    gpio_prio_pick #(.WIDTH(NUM_PINS)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .live_i  (live_val),
        .valid_o (pick_valid),
        .index_o (pick_index)
    );

    assign vec_word = {pick_valid, PIN_GROUP_CODE, pick_index};

    always_comb begin
        unique case (sel)
            SEL_CAUSE:  bus_rdata = cause_val;
            SEL_MASK:   bus_rdata = mask_val;
            SEL_VECTOR: bus_rdata = {{(NUM_PINS-VEC_W){1'b0}}, vec_word};
            default:    bus_rdata = '0;
        endcase
    end

    AST_CASCADE_MATCHES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_irq) == pick_valid); // R6
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(!rst_n) |-> (grp_irq == '0)); // R1
endmodule

// File: tb/gpio_irq_collector_test.sv
module gpio_irq_collector_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 6;

    // {mask, pin pattern, expected cascade, expected vector}
    localparam logic [99:0] VECTORS [ROWS] = '{
        {32'hFFFF_FFFF, 32'h0000_0001, 4'h1, 32'h0000_00C0},
        {32'hFFFF_FFFF, 32'h8000_0001, 4'h9, 32'h0000_00DF},
        {32'h0000_FFFF, 32'h00F0_0100, 4'h2, 32'h0000_00C8},
        {32'h0000_0000, 32'hFFFF_FFFF, 4'h0, 32'h0000_0040},
        {32'h00FF_0000, 32'h0081_0000, 4'h4, 32'h0000_00D7},
        {32'h0F0F_0F0F, 32'hF0F0_F0F8, 4'h1, 32'h0000_00C3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  grp_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_collector uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq(grp_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        rd(5'h08, rv); check("R1 cause", rv, 32'h0);
        rd(5'h0C, rv); check("R1 mask", rv, 32'h0);
        rd(5'h10, rv); check("R1 vector", rv, 32'h40);
        check("R1 cascade", {28'h0, grp_irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // table walk: R2 capture, R5 readback, R6 cascade, R7 vector, R8 masked
        for (int r = 0; r < ROWS; r++) begin
            pin_i = '0;
            idle(4);
            wr(5'h08, 32'h0);
            wr(5'h0C, VECTORS[r][99:68]);
            pin_i = VECTORS[r][67:36];
            idle(5);
            pin_i = '0;
            idle(4);
            rd(5'h08, rv); check("R2 R8 cause", rv, VECTORS[r][67:36]);
            rd(5'h0C, rv); check("R5 mask", rv, VECTORS[r][99:68]);
            check("R6 cascade", {28'h0, grp_irq}, {28'h0, VECTORS[r][35:32]});
            rd(5'h10, rv); check("R7 vector", rv, VECTORS[r][31:0]);
        end

        // R3 acknowledge one pin with the inverted pattern
        wr(5'h08, ~(32'h1 << 3));
        rd(5'h08, rv); check("R3 one-pin ack", rv, 32'hF0F0_F0F0);
        check("R3 cascade drop", {28'h0, grp_irq}, 32'h0);
        rd(5'h10, rv); check("R3 vector idle", rv, 32'h40);

        // R9 writes to vector and unmapped offsets are ignored
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h0);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h08, rv); check("R9 cause kept", rv, 32'hF0F0_F0F0);
        rd(5'h0C, rv); check("R9 mask kept", rv, 32'h0F0F_0F0F);
        rd(5'h04, rv); check("R9 unmapped read", rv, 32'h0);

        // R2 a level held high does not set the bit again
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF);
        pin_i = 32'h20;
        idle(5);
        wr(5'h08, 32'h0);
        idle(6);
        rd(5'h08, rv); check("R2 no re-set on level", rv, 32'h0);
        pin_i = '0;
        idle(4);

        // R2 exact latency: set visible after the third edge
        pin_i = 32'h400;
        @(negedge clk); @(negedge clk);
        rd(5'h08, rv); check("R2 not yet set", rv, 32'h0);
        @(negedge clk);
        rd(5'h08, rv); check("R2 set on third edge", rv, 32'h400);
        pin_i = '0;
        idle(4);
        wr(5'h08, 32'h0);

        // R4 edge and zero write in the same cycle: set wins
        @(negedge clk);
        pin_i = 32'h200;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = ~(32'h200);
        @(negedge clk);
        bus_we = 1'b0;
        rd(5'h08, rv); check("R4 set beats clear", rv, 32'h200);
        rd(5'h10, rv); check("R4 vector", rv, 32'hC9);
        pin_i = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule